// File: doc/BRIEF.md
# Nibble-Addressed Divider Configuration Latches

This block collects the three divide settings of a frequency synthesizer through a narrow parallel port. A host places a 4-bit value on the data bus, selects one of eight slots with a 3-bit address and raises a strobe. While the strobe stays high, the addressed slot follows the bus on every system clock edge. When the strobe drops, the slot keeps the last value it took. Holding the strobe low keeps every slot frozen, so the bus and address may change freely.

The eight slots are packed into three words of different widths. Two slots make the 7-bit swallow count. Three slots make the 10-bit main count. Three more make the 12-bit reference count. Slots that feed the top of a word keep only the bus bits that word needs. The other bits on the bus are dropped, and every word bit reads as zero until it is loaded. The real level-sensitive latches are modelled as registers that sample the strobe level in one clock domain.

Top module: `nibble_cfg_latches`

## Requirements
- R1: While `rst` is high, at the next clock edge all three words become zero, and they stay zero until a slot is loaded.
- R2: When `cfgStrobe` is high at a clock edge, the slot chosen by `cfgAddr` takes `cfgData`, and the matching word bits show it after that edge. `cfgData[3]` is the most significant bit of the nibble.
- R3: When `cfgStrobe` is low at a clock edge, no word bit changes, whatever `cfgAddr` and `cfgData` carry.
- R4: While the strobe is held high over several edges, the slot follows each new bus value. After the strobe falls, the slot keeps the value it took at the last edge with the strobe high.
- R5: The swallow word is built from slot 0, which gives bits 3..0, and slot 1, which gives bits 6..4 from `cfgData[2:0]`. `cfgData[3]` has no effect when slot 1 is loaded.
- R6: The main word is built from slot 2 (bits 3..0), slot 3 (bits 7..4) and slot 4 (bits 9..8, from `cfgData[1:0]`). `cfgData[3:2]` have no effect when slot 4 is loaded.
- R7: The reference word is built from slots 5, 6 and 7, which give bits 3..0, 7..4 and 11..8 in that order.
- R8: A load of one slot leaves the word bits of every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgData | input | 4 | Nibble to load; bit 3 is the MSB |
| cfgAddr | input | 3 | Slot select, 0 to 7 |
| cfgStrobe | input | 1 | Load enable, active while high |
| swallowWord | output | 7 | Swallow count from slots 0 and 1 |
| mainWord | output | 10 | Main count from slots 2 to 4 |
| refWord | output | 12 | Reference count from slots 5 to 7 |

## Verification
The assertions assume that the strobe, address and data are synchronous to `clk` and hold one defined value at each rising edge. They also assume that every address names a real slot, which is true because the default sizing fills all eight codes. The bench changes inputs only on the falling clock edge. It draws addresses from the full 3-bit range and mixes long strobe-high runs, where the data changes while the strobe is held, with long strobe-low runs, so that both the following behaviour and the holding behaviour are tested.

// File: rtl/cfg_latch_pkg.sv
package cfg_latch_pkg;
  localparam int NIB_W   = 4;
  localparam int ADDR_W  = 3;
  localparam int SLOTS   = 1 << ADDR_W;

  typedef struct packed {
    logic             load;
    logic [SLOTS-1:0] slotSel;
  } wr_ctl_t;
endpackage

// File: rtl/cfg_latch_ctrl.sv
module cfg_latch_ctrl
  import cfg_latch_pkg::*;
(
  input  logic              strobeIn,
  input  logic [ADDR_W-1:0] addrIn,
  output wr_ctl_t           wrCtl
);
  always_comb begin
    wrCtl.load    = strobeIn;
    wrCtl.slotSel = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (strobeIn && (addrIn == ADDR_W'(i))) wrCtl.slotSel[i] = 1'b1;
    end
  end
endmodule

// File: rtl/cfg_latch_dp.sv
module cfg_latch_dp
  import cfg_latch_pkg::*;
#(
  parameter int SW_W  = 7,
  parameter int MN_W  = 10,
  parameter int RF_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] dataIn,
  input  wr_ctl_t          wrCtl,
  output logic [SW_W-1:0]  swallowOut,
  output logic [MN_W-1:0]  mainOut,
  output logic [RF_W-1:0]  refOut
);
  localparam int SW_SLOTS = (SW_W + NIB_W - 1) / NIB_W;
  localparam int MN_SLOTS = (MN_W + NIB_W - 1) / NIB_W;
  localparam int RF_SLOTS = (RF_W + NIB_W - 1) / NIB_W;
  localparam int USED     = SW_SLOTS + MN_SLOTS + RF_SLOTS;
  localparam int TOTAL_W  = SW_W + MN_W + RF_W;

  function automatic int slotBits(input int s);
    int rem;
    if (s < SW_SLOTS)                 rem = SW_W - s * NIB_W;
    else if (s < SW_SLOTS + MN_SLOTS) rem = MN_W - (s - SW_SLOTS) * NIB_W;
    else                              rem = RF_W - (s - SW_SLOTS - MN_SLOTS) * NIB_W;
    return (rem > NIB_W) ? NIB_W : rem;
  endfunction

  function automatic int slotOff(input int s);
    int acc = 0;
    for (int j = 0; j < s; j++) acc += slotBits(j);
    return acc;
  endfunction

  logic [TOTAL_W-1:0] cfgBits;
  logic [TOTAL_W-1:0] nextBits;

  for (genvar g = 0; g < USED; g++) begin : g_slot
    localparam int BITS = slotBits(g);
    localparam int OFF  = slotOff(g);
    assign nextBits[OFF +: BITS] = wrCtl.slotSel[g] ? dataIn[BITS-1:0]
                                                    : cfgBits[OFF +: BITS];
  end

  always_ff @(posedge clk) begin
    if (rst) cfgBits <= '0;
    else     cfgBits <= nextBits;
  end

  assign swallowOut = cfgBits[0 +: SW_W];
  assign mainOut    = cfgBits[SW_W +: MN_W];
  assign refOut     = cfgBits[SW_W + MN_W +: RF_W];
endmodule

// File: rtl/nibble_cfg_latches.sv
module nibble_cfg_latches
  import cfg_latch_pkg::*;
#(
  parameter int SW_W = 7,
  parameter int MN_W = 10,
  parameter int RF_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NIB_W-1:0]  cfgData,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgStrobe,
  output logic [SW_W-1:0]   swallowWord,
  output logic [MN_W-1:0]   mainWord,
  output logic [RF_W-1:0]   refWord
);
  wr_ctl_t wrCtl;

  cfg_latch_ctrl u_ctrl (
    .strobeIn (cfgStrobe),
    .addrIn   (cfgAddr),
    .wrCtl    (wrCtl)
  );

  cfg_latch_dp #(.SW_W(SW_W), .MN_W(MN_W), .RF_W(RF_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .dataIn     (cfgData),
    .wrCtl      (wrCtl),
    .swallowOut (swallowWord),
    .mainOut    (mainWord),
    .refOut     (refWord)
  );
endmodule

// File: rtl/cfg_latch_chk.sv
module cfg_latch_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  cfgData,
  input logic [2:0]  cfgAddr,
  input logic        cfgStrobe,
  input logic [6:0]  swallowWord,
  input logic [9:0]  mainWord,
  input logic [11:0] refWord
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (swallowWord == '0 && mainWord == '0 && refWord == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfgStrobe |=> ($stable(swallowWord) && $stable(mainWord) && $stable(refWord)));

  // R2
  slot0_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cfgStrobe && cfgAddr == 3'd0) |=> (swallowWord[3:0] == $past(cfgData)));

  // R5
  slot1_trim_chk: assert property (@(posedge clk) disable iff (rst)
    (cfgStrobe && cfgAddr == 3'd1) |=> (swallowWord[6:4] == $past(cfgData[2:0])));

  // R6
  slot4_trim_chk: assert property (@(posedge clk) disable iff (rst)
    (cfgStrobe && cfgAddr == 3'd4) |=> (mainWord[9:8] == $past(cfgData[1:0])));

  // R7
  slot7_top_chk: assert property (@(posedge clk) disable iff (rst)
    (cfgStrobe && cfgAddr == 3'd7) |=> (refWord[11:8] == $past(cfgData)));

  // R8
  swallow_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    (cfgStrobe && cfgAddr > 3'd1) |=> $stable(swallowWord));
endmodule

bind nibble_cfg_latches cfg_latch_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfgData     (cfgData),
  .cfgAddr     (cfgAddr),
  .cfgStrobe   (cfgStrobe),
  .swallowWord (swallowWord),
  .mainWord    (mainWord),
  .refWord     (refWord)
);

// File: tb/sim_nibble_cfg_latches.sv
module sim_nibble_cfg_latches;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfgData = '0;
  logic [2:0]  cfgAddr = '0;
  logic        cfgStrobe = 1'b0;
  logic [6:0]  swallowWord;
  logic [9:0]  mainWord;
  logic [11:0] refWord;

  int testCnt = 0;
  int failCnt = 0;
  logic [3:0] model [8];

  always #10 clk = ~clk;

  nibble_cfg_latches u0 (
    .clk(clk), .rst(rst), .cfgData(cfgData), .cfgAddr(cfgAddr),
    .cfgStrobe(cfgStrobe), .swallowWord(swallowWord),
    .mainWord(mainWord), .refWord(refWord)
  );

  function automatic logic [6:0] expSw();
    return {model[1][2:0], model[0]};
  endfunction
  function automatic logic [9:0] expMn();
    return {model[4][1:0], model[3], model[2]};
  endfunction
  function automatic logic [11:0] expRf();
    return {model[7], model[6], model[5]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check({req, " swallow"}, 32'(swallowWord), 32'(expSw()));
    check({req, " main"},    32'(mainWord),    32'(expMn()));
    check({req, " ref"},     32'(refWord),     32'(expRf()));
  endtask

  // drive at negedge, one posedge, compare at next negedge
  task automatic step(input logic s, input logic [2:0] a, input logic [3:0] d);
    cfgStrobe = s; cfgAddr = a; cfgData = d;
    @(posedge clk);
    if (s) model[a] = d;
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; cfgStrobe = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 8; i++) model[i] = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) model[i] = 'x;
    @(negedge clk);
    doReset();
    checkAll("R1 reset");

    step(1'b1, 3'd0, 4'hA);
    check("R2 slot0", 32'(swallowWord), 32'h0A);
    step(1'b0, 3'd0, 4'h3);

    step(1'b1, 3'd5, 4'h3);
    step(1'b1, 3'd5, 4'h9);
    check("R4 follow", 32'(refWord[3:0]), 32'h9);
    step(1'b0, 3'd5, 4'hF);
    step(1'b0, 3'd5, 4'h6);
    check("R4 hold after fall", 32'(refWord[3:0]), 32'h9);

    for (int i = 0; i < 8; i++) step(1'b0, 3'(i), 4'(15 - i));
    checkAll("R3 idle");

    step(1'b1, 3'd1, 4'hF);
    check("R5 swallow pack", 32'(swallowWord), 32'h7A);

    step(1'b1, 3'd4, 4'hF);
    check("R6 main top", 32'(mainWord), 32'h300);
    step(1'b1, 3'd2, 4'h5);
    step(1'b1, 3'd3, 4'hC);
    check("R6 main pack", 32'(mainWord), 32'h3C5);

    step(1'b1, 3'd5, 4'h1);
    step(1'b1, 3'd6, 4'h2);
    step(1'b1, 3'd7, 4'h3);
    check("R7 ref pack", 32'(refWord), 32'h321);
    check("R8 others kept", 32'(swallowWord), 32'h7A);

    for (int n = 0; n < 400; n++) begin
      logic s;
      s = (($urandom % 4) == 0) ? ~cfgStrobe : cfgStrobe;
      step(s, 3'($urandom % 8), 4'($urandom % 16));
      checkAll(s ? "R2 R8 random load" : "R3 random idle");
    end

    doReset();
    checkAll("R1 reset mid-run");
    finishRun();
  end
endmodule